// File: doc/BRIEF.md
# Keypad Sequence Lock Controller

This block drives a door latch from a stream of keypad events. Each event is a one-cycle strobe together with a 4-bit key code that has already been decoded and debounced upstream. The latch is released only when three keys arrive in a fixed order: the digit 3, then the digit 9, then the '#' key. The code is fixed at build time through parameters.

The controller is a Moore machine with four states. The states are idle, first key accepted, second key accepted and open, and each state has its own flip-flop (one-hot). An inactivity timer starts when the first correct key is accepted. If the sequence has not finished within a fixed number of cycles, the timer sends the machine back to idle. The open state is left the same way. The system clock is meant to be 200 Hz, divided down from a 24 MHz reference, so the default limit of 6000 cycles gives a 30 s window.

Top module: `keylock_ctrl`

## Requirements
- R1: While rst_i is high and in the first cycle after it, latch_o is low and the machine is idle.
- R2: Strobed keys 0x3, 0x9 and 0xF ('#'), in that order, raise latch_o in the cycle after the edge that samples 0xF. latch_o rises at no other time.
- R3: The state register is one-hot: exactly one of its four bits is set at every cycle out of reset.
- R4: A key code is acted on only in a cycle where key_vld_i is high. Codes presented with the strobe low have no effect.
- R5: A wrong key while one or two correct keys are held returns the machine to idle. If that wrong key is 0x3, the machine goes to the first-key-accepted state instead.
- R6: Key codes are 0x0 to 0x9 for digits, 0xE for '*' and 0xF for '#'. In idle, every strobed key except 0x3 leaves the machine idle.
- R7: In the open state, all strobed keys are ignored and latch_o stays high until reset or timeout.
- R8: TIMEOUT cycles (default 6000) after the most recent entry into the first-key-accepted state, the machine is idle and latch_o is low. A key sampled on the edge that ends the window is ignored.
- R9: Accepting 0x3 again restarts the timeout window from that edge.
- R10: latch_o is a function of the current state only (Moore output) and matches a cycle-level reference on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (200 Hz in the target use) |
| rst_i | input | 1 | Synchronous reset, active high |
| key_vld_i | input | 1 | Single-cycle strobe marking a key event |
| key_i | input | 4 | Decoded key code, valid with the strobe |
| latch_o | output | 1 | Door latch drive, high while open |

## Verification
The unlock path is tried with the clean sequence 3-9-# and with sequences broken by a foreign digit, by '*', by a repeated 3 and by a 3 that arrives in the middle. These separate the plain fall-back to idle from the fall-back to the first-key-accepted state. Codes held on key_i with the strobe low show that unstrobed values are ignored. Keys pressed while open show that the latch is held. Timed runs place '#' on the last edge of the window and on the edge just after it, and re-press 3 late in the window. These runs pin down exactly where the timeout ends the window and show that it restarts.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
    localparam int unsigned NUM_ST  = 4;
    localparam int unsigned ST_IDLE = 0;
    localparam int unsigned ST_ONE  = 1;
    localparam int unsigned ST_TWO  = 2;
    localparam int unsigned ST_OPEN = 3;

    typedef logic [NUM_ST-1:0] state_t;

    localparam state_t OH_IDLE = state_t'(1) << ST_IDLE;
    localparam state_t OH_ONE  = state_t'(1) << ST_ONE;
    localparam state_t OH_TWO  = state_t'(1) << ST_TWO;
    localparam state_t OH_OPEN = state_t'(1) << ST_OPEN;

    typedef struct packed {
        state_t st;
    } fsm_regs_t;
endpackage

// File: rtl/keylock_idle_timer.sv
module keylock_idle_timer #(
    parameter int unsigned LIMIT = 6000,
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    assign expire_o = run_i && (r_q.cnt == CNT_W'(LIMIT - 1));

    always_comb begin
        r_d = r_q;
        if (restart_i) begin
            r_d.cnt = '0;
        end else if (!run_i || expire_o) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/keylock_seq_fsm.sv
module keylock_seq_fsm
    import keylock_pkg::*;
#(
    parameter int unsigned      KEY_W = 4,
    parameter logic [KEY_W-1:0] CODE0 = 4'h3,
    parameter logic [KEY_W-1:0] CODE1 = 4'h9,
    parameter logic [KEY_W-1:0] CODE2 = 4'hF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             key_vld_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             expire_i,
    output state_t           state_o,
    output logic             busy_o,
    output logic             restart_o
);
    fsm_regs_t r_d, r_q;

    assign state_o = r_q.st;
    assign busy_o  = !r_q.st[ST_IDLE];

    always_comb begin
        r_d       = r_q;
        restart_o = 1'b0;
        if (expire_i) begin
            r_d.st = OH_IDLE;
        end else if (key_vld_i && !r_q.st[ST_OPEN]) begin
            if (r_q.st[ST_ONE] && key_i == CODE1) begin
                r_d.st = OH_TWO;
            end else if (r_q.st[ST_TWO] && key_i == CODE2) begin
                r_d.st = OH_OPEN;
            end else if (key_i == CODE0) begin
                r_d.st    = OH_ONE;
                restart_o = 1'b1;
            end else begin
                r_d.st = OH_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.st <= OH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
    import keylock_pkg::*;
#(
    parameter int unsigned      TIMEOUT = 6000,
    parameter int unsigned      KEY_W   = 4,
    parameter logic [KEY_W-1:0] CODE0   = 4'h3,
    parameter logic [KEY_W-1:0] CODE1   = 4'h9,
    parameter logic [KEY_W-1:0] CODE2   = 4'hF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             key_vld_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             latch_o
);
    state_t state;
    logic   busy;
    logic   restart;
    logic   expire;

    keylock_seq_fsm #(
        .KEY_W (KEY_W),
        .CODE0 (CODE0),
        .CODE1 (CODE1),
        .CODE2 (CODE2)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .key_vld_i (key_vld_i),
        .key_i     (key_i),
        .expire_i  (expire),
        .state_o   (state),
        .busy_o    (busy),
        .restart_o (restart)
    );

    keylock_idle_timer #(
        .LIMIT (TIMEOUT)
    ) u_tmr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (busy),
        .restart_i (restart),
        .expire_o  (expire)
    );

    assign latch_o = state[ST_OPEN];
endmodule

// File: rtl/keylock_ctrl_chk.sv
module keylock_ctrl_chk
    import keylock_pkg::*;
#(
    parameter int unsigned      KEY_W = 4,
    parameter logic [KEY_W-1:0] CODE2 = 4'hF
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             key_vld_i,
    input logic [KEY_W-1:0] key_i,
    input logic             latch_o,
    input state_t           state,
    input logic             expire
);
    p_onehot_state_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(state) == 1);

    p_open_after_hash_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(latch_o) |-> $past(key_vld_i && key_i == CODE2));

    p_idle_needs_strobe_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state[ST_IDLE] && !key_vld_i) |=> state[ST_IDLE]);

    p_open_holds_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (latch_o && !expire) |=> latch_o);

    p_timeout_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        expire |=> (state[ST_IDLE] && !latch_o));
endmodule

bind keylock_ctrl keylock_ctrl_chk #(
    .KEY_W (KEY_W),
    .CODE2 (CODE2)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .key_vld_i (key_vld_i),
    .key_i     (key_i),
    .latch_o   (latch_o),
    .state     (state),
    .expire    (expire)
);

// File: tb/keylock_ctrl_test.sv
`timescale 1ns/1ps
module keylock_ctrl_test;
    localparam int LIMIT = 6000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vld = 1'b0;
    logic [3:0] key = 4'h0;
    logic       latch;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference model state: 0 idle, 1 one key, 2 two keys, 3 open
    int m_st  = 0;
    int m_age = 0;

    always #5 clk = ~clk;

    keylock_ctrl uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .key_vld_i (vld),
        .key_i     (key),
        .latch_o   (latch)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_st  = 0;
            m_age = 0;
        end else if (m_st != 0 && m_age == LIMIT - 1) begin
            m_st  = 0;
            m_age = 0;
        end else begin
            int nx;
            bit rs;
            nx = m_st;
            rs = 0;
            if (vld && m_st != 3) begin
                if (m_st == 1 && key == 4'h9) nx = 2;
                else if (m_st == 2 && key == 4'hF) nx = 3;
                else if (key == 4'h3) begin nx = 1; rs = 1; end
                else nx = 0;
            end
            if (rs) m_age = 0;
            else if (nx == 0) m_age = 0;
            else m_age = m_age + 1;
            m_st = nx;
        end
    end

    // per-cycle comparison against the reference (R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (latch !== (m_st == 3)) begin
                fails++;
                $display("FAIL R10 model cycle %0d: latch=%0b expected=%0b", cyc, latch, (m_st == 3));
            end
        end
    end

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] k);
        @(negedge clk);
        vld = 1'b1;
        key = k;
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(latch, 1'b0, "R1 latch low during reset");
        rst = 1'b0;
        @(negedge clk);
        chk(latch, 1'b0, "R1 latch low after reset");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R2 clean sequence; R7 keys in open state ignored
        press(4'h3); press(4'h9);
        chk(latch, 1'b0, "R2 closed before hash");
        press(4'hF);
        chk(latch, 1'b1, "R2 open after 3 9 #");
        press(4'h0); press(4'h3); press(4'hE);
        chk(latch, 1'b1, "R7 open held through keys");
        // 5 presses after the '3' edge (10 negedges); R8 window end
        repeat (LIMIT - 11) @(negedge clk);
        chk(latch, 1'b1, "R8 open on last window cycle");
        @(negedge clk);
        chk(latch, 1'b0, "R8 closed after timeout");

        // R4 unstrobed codes ignored
        do_reset();
        key = 4'h3; repeat (3) @(negedge clk);
        key = 4'h9; repeat (3) @(negedge clk);
        press(4'hF);
        chk(latch, 1'b0, "R4 unstrobed 3 9 ignored");

        // R6 wrong keys in idle
        press(4'hF); press(4'hE); press(4'h9); press(4'hF);
        chk(latch, 1'b0, "R6 idle ignores non-3 keys");

        // R5 wrong digit mid sequence
        press(4'h3); press(4'h5); press(4'h9); press(4'hF);
        chk(latch, 1'b0, "R5 wrong digit returns idle");
        press(4'h3); press(4'h9); press(4'hE); press(4'hF);
        chk(latch, 1'b0, "R5 star breaks sequence");
        press(4'h3); press(4'h9); press(4'h3); press(4'h9); press(4'hF);
        chk(latch, 1'b1, "R5 stray 3 goes to first-key state");
        do_reset();
        press(4'h3); press(4'h3); press(4'h9); press(4'hF);
        chk(latch, 1'b1, "R5 repeated 3 accepted");

        // R8 boundary: '#' on last edge of window
        do_reset();
        press(4'h3); press(4'h9);
        repeat (LIMIT - 5) @(negedge clk);
        press(4'hF);
        chk(latch, 1'b1, "R8 hash on final window edge opens");
        @(negedge clk);
        chk(latch, 1'b0, "R8 one-cycle open then timeout");

        // R8 '#' one edge too late
        press(4'h3); press(4'h9);
        repeat (LIMIT - 4) @(negedge clk);
        press(4'hF);
        chk(latch, 1'b0, "R8 hash after window ignored");

        // R9 re-pressing 3 restarts window
        press(4'h3);
        repeat (LIMIT - 20) @(negedge clk);
        press(4'h3);
        repeat (100) @(negedge clk);
        press(4'h9); press(4'hF);
        chk(latch, 1'b1, "R9 restarted window allows open");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule